// File: doc/BRIEF.md
# Reference Frequency Classifier

This block works out the rate of one reference input by counting its edges against a local freerun clock. The reference reaches the block as a strobe that is already synchronized: one freerun cycle high for each reference edge. Edges are counted over gates of a fixed number of freerun cycles. The gates run back to back, so a new result comes out once per gate with no software action. Each count is turned into a fixed-point value of the count and compared with the nominal count that a candidate rate would produce in one gate.

The block has two modes. In automatic mode it compares the count with a fixed set of thirteen telecom and Ethernet rates and reports which one matches. In manual mode it compares the count with a single target of N times 8 kHz. When a match is found, it also reports how far the input is from the nominal value, as a signed offset in parts per million (ppm). It uses a serial divider for this.

Top module: `ref_freq_classifier`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next edge leaves `match_valid` at 0, `freq_idx` at 0 and `offset_ppm` at 0.
- R2: Reference strobes are counted over back-to-back gates of `GATE_CYCLES` freerun cycles. The three outputs change only when a gate result is published, at most once per gate, and hold their values in between.
- R3: In automatic mode (`manual_mode` = 0), the index code is assigned in ascending order of rate: 0 = 8 kHz, 1 = 64 kHz, 2 = 1.544 MHz, 3 = 2.048 MHz, 4 = 6.48 MHz, 5 = 8.192 MHz, 6 = 16.384 MHz, 7 = 19.44 MHz, 8 = 25 MHz, 9 = 38.88 MHz, 10 = 50 MHz, 11 = 77.76 MHz, 12 = 125 MHz.
- R4: The nominal count of a rate f is f·`GATE_CYCLES`/`FREE_HZ`. A count C lies in a candidate's band when |C − nominal| ≤ nominal·`TOL_PPM`/10^6 + 1 count.
- R5: When the count lies in the bands of several automatic candidates, the lowest index is reported.
- R6: When no candidate band holds the count, `match_valid` = 0, `freq_idx` = 0 and `offset_ppm` = 0.
- R7: In manual mode (`manual_mode` = 1), the only candidate is `n_mult` × 8 kHz, and a match reports index code 15. `n_mult` = 0 never matches.
- R8: On a match, `offset_ppm` = (C − nominal)·10^6/nominal, truncated toward zero, to within 1 ppm.
- R9: An offset whose magnitude exceeds 2^(`OFS_W`−1)−1 is clamped to ±(2^(`OFS_W`−1)−1). The most negative code never appears.
- R10: A change of input rate or of mode shows up at the outputs within two gates plus the pipeline latency, with no reset in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Freerun clock; also the time base for the gate |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_edge | input | 1 | Synchronized reference edge strobe, one cycle per edge |
| manual_mode | input | 1 | 0 = match against the fixed table, 1 = match against the N×8 kHz target |
| n_mult | input | 15 | Multiplier N for the manual target |
| freq_idx | output | 4 | Matched index: 0..12 from the table, 15 in manual mode |
| match_valid | output | 1 | 1 when the last gate's count matched a candidate |
| offset_ppm | output | OFS_W | Signed offset from the nominal rate, in ppm |

## Verification
The bench sets the exact number of strobes per gate, so every result it expects is exact. It tries counts one step inside and one step outside a tolerance band. A block that drops the one-count slack would reject the 25 MHz case that is one count high. A block with too much slack would accept the count two above it.

The lowest rates share a band at this short gate, which tests the priority rule: a reversed search would report 64 kHz instead of 8 kHz. The 8 kHz case with a count of one tests clamping: a block that wraps instead of clamping gives a negative offset. Manual mode is tested with N = 0, so a block that lets a zero target match a zero count is caught. Rate and mode changes without a reset, plus a check that the outputs hold across a gate, catch results that are published late or that wander between gates.

// File: rtl/rfc_pkg.sv
// Shared constants and elaboration-time helpers for the reference
// frequency classifier. Assumes real arithmetic is available when
// parameters are evaluated; nothing here produces hardware.
package rfc_pkg;

    localparam int              RATE_COUNT = 13;
    localparam int              IDX_W      = 4;
    localparam logic [IDX_W-1:0] IDX_MANUAL = 4'hF;
    localparam longint          STEP_HZ    = 64'd8000;
    localparam int              N_W        = 15;

    // Candidate rate in Hz for a table index, ascending order (R3).
    function automatic longint rate_hz(input int sel);
        case (sel)
            0:       return 64'd8_000;
            1:       return 64'd64_000;
            2:       return 64'd1_544_000;
            3:       return 64'd2_048_000;
            4:       return 64'd6_480_000;
            5:       return 64'd8_192_000;
            6:       return 64'd16_384_000;
            7:       return 64'd19_440_000;
            8:       return 64'd25_000_000;
            9:       return 64'd38_880_000;
            10:      return 64'd50_000_000;
            11:      return 64'd77_760_000;
            default: return 64'd125_000_000;
        endcase
    endfunction

    // Expected edges per gate for a rate, scaled by 2^frac and rounded.
    function automatic longint scaled_count(input longint hz, input longint gate,
                                            input longint free, input int frac);
        real r;
        r = real'(hz) * real'(gate) * (2.0 ** frac) / real'(free);
        return longint'(r);
    endfunction

endpackage

// File: rtl/rfc_gate.sv
// Gate timer and edge counter. Counts edge strobes over back-to-back
// windows of GATE_CYCLES clocks and publishes each total with a
// one-cycle valid pulse. Assumes at most one strobe per clock.
module rfc_gate #(
    parameter int GATE_CYCLES = 250000,
    parameter int CNT_W       = $clog2(GATE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_stb,
    output logic [CNT_W-1:0] meas_cnt,
    output logic             meas_vld
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(GATE_CYCLES - 1);

    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] run_cnt;

    // Advance the gate position, accumulate strobes, publish at gate end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= '0;
            run_cnt  <= '0;
            meas_cnt <= '0;
            meas_vld <= 1'b0;
        end else begin
            meas_vld <= 1'b0;
            if (pos == LAST_POS) begin
                pos      <= '0;
                run_cnt  <= '0;
                meas_cnt <= run_cnt + CNT_W'(edge_stb);
                meas_vld <= 1'b1;
            end else begin
                pos     <= pos + 1'b1;
                run_cnt <= run_cnt + CNT_W'(edge_stb);
            end
        end
    end

    AST_COUNT_WITHIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= pos); // R2

    AST_PUBLISH_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld |-> pos == '0); // R2

endmodule

// File: rtl/rfc_match.sv
// Candidate matcher. Converts a gate count to fixed point, tests it
// against every table rate (automatic) or the N x 8 kHz target
// (manual), picks the lowest matching index, and registers the hit,
// the index, the nominal count and the signed difference.
// Assumes TOL_PPM < 2^20 and ACC_W wide enough for 8x the gate count.
module rfc_match #(
    parameter int     GATE_CYCLES = 250000,
    parameter longint FREE_HZ     = 250_000_000,
    parameter int     TOL_PPM     = 100,
    parameter int     FRAC        = 24,
    parameter int     CNT_W       = $clog2(GATE_CYCLES + 1),
    parameter int     ACC_W       = CNT_W + FRAC + 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        meas_vld,
    input  logic [CNT_W-1:0]            meas_cnt,
    input  logic                        manual_mode,
    input  logic [rfc_pkg::N_W-1:0]     n_mult,
    output logic                        cls_vld,
    output logic                        cls_hit,
    output logic [rfc_pkg::IDX_W-1:0]   cls_idx,
    output logic [ACC_W-1:0]            cls_nom,
    output logic signed [ACC_W-1:0]     cls_diff
);

    import rfc_pkg::*;

    localparam int     PW      = ACC_W + 21;
    localparam int     MW      = ACC_W + N_W;
    localparam longint STEP_FX = scaled_count(STEP_HZ, GATE_CYCLES, FREE_HZ, FRAC);

    logic [ACC_W-1:0] meas_fx;
    logic [ACC_W-1:0] tbl_nom [RATE_COUNT];
    logic [RATE_COUNT-1:0] tbl_hit;
    logic [MW-1:0]    man_prod;
    logic [ACC_W-1:0] man_nom;
    logic             man_hit;
    logic             sel_hit;
    logic [IDX_W-1:0] sel_idx;
    logic [ACC_W-1:0] sel_nom;

    // Band test: |m - nom| * 1e6 <= nom * TOL + 1e6 counts of slack.
    function automatic logic in_band(input logic [ACC_W-1:0] m, input logic [ACC_W-1:0] nom);
        logic [ACC_W-1:0] d;
        logic [PW-1:0]    lhs;
        logic [PW-1:0]    rhs;
        d   = (m >= nom) ? (m - nom) : (nom - m);
        lhs = PW'(d) * PW'(1_000_000);
        rhs = PW'(nom) * PW'(TOL_PPM) + (PW'(1_000_000) << FRAC);
        return lhs <= rhs;
    endfunction

    assign meas_fx = ACC_W'(meas_cnt) << FRAC;

    // One fixed comparator per table rate.
    for (genvar k = 0; k < RATE_COUNT; k++) begin : g_rate
        localparam logic [ACC_W-1:0] NOM_K =
            ACC_W'(scaled_count(rate_hz(k), GATE_CYCLES, FREE_HZ, FRAC));
        assign tbl_nom[k] = NOM_K;
        assign tbl_hit[k] = in_band(meas_fx, NOM_K);
    end

    // Manual target, rejected for N = 0 or when it exceeds the range.
    always_comb begin
        man_prod = MW'(n_mult) * MW'(STEP_FX);
        man_nom  = man_prod[ACC_W-1:0];
        man_hit  = (n_mult != '0) && (man_prod[MW-1:ACC_W] == '0) && in_band(meas_fx, man_nom);
    end

    // Select the candidate: manual target, or lowest table index.
    always_comb begin
        sel_hit = 1'b0;
        sel_idx = '0;
        sel_nom = '0;
        if (manual_mode) begin
            sel_hit = man_hit;
            sel_idx = man_hit ? IDX_MANUAL : '0;
            sel_nom = man_nom;
        end else begin
            for (int k = RATE_COUNT - 1; k >= 0; k--) begin
                if (tbl_hit[k]) begin
                    sel_hit = 1'b1;
                    sel_idx = IDX_W'(k);
                    sel_nom = tbl_nom[k];
                end
            end
        end
    end

    // Register the classification once per published gate count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_vld  <= 1'b0;
            cls_hit  <= 1'b0;
            cls_idx  <= '0;
            cls_nom  <= '0;
            cls_diff <= '0;
        end else begin
            cls_vld <= meas_vld;
            if (meas_vld) begin
                cls_hit  <= sel_hit;
                cls_idx  <= sel_idx;
                cls_nom  <= sel_nom;
                cls_diff <= $signed(meas_fx) - $signed(sel_nom);
            end
        end
    end

    AST_HIT_HAS_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_vld && cls_hit) |-> cls_nom != '0); // R7

    AST_VALID_FOLLOWS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld |=> cls_vld); // R2

endmodule

// File: rtl/rfc_ppm_div.sv
// Serial offset divider. Computes |diff| * 1e6 / nom one quotient bit
// per clock, restores the sign (truncation toward zero), and clamps to
// the symmetric range of OFS_W bits. Takes OFS_W - 1 cycles unless it
// clamps at once. Assumes start never arrives while busy.
module rfc_ppm_div #(
    parameter int ACC_W = 45,
    parameter int OFS_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [ACC_W-1:0] diff,
    input  logic [ACC_W-1:0]        nom,
    output logic                    done,
    output logic signed [OFS_W-1:0] quot
);

    localparam int DW = ACC_W + OFS_W + 21;
    localparam int SW = $clog2(OFS_W);
    localparam logic signed [OFS_W-1:0] QMAX = {1'b0, {(OFS_W-1){1'b1}}};

    logic [ACC_W-1:0] mag;
    logic [DW-1:0]    num;
    logic [DW-1:0]    lim;
    logic [DW-1:0]    rem;
    logic [DW-1:0]    den_sh;
    logic [OFS_W-2:0] q;
    logic [OFS_W-2:0] q_next;
    logic [SW-1:0]    step;
    logic             busy;
    logic             neg;
    logic             take;

    // Operand magnitude, scaled numerator and the clamp limit.
    always_comb begin
        mag = diff[ACC_W-1] ? ACC_W'(-diff) : ACC_W'(diff);
        num = DW'(mag) * DW'(1_000_000);
        lim = DW'(nom) << (OFS_W - 1);
    end

    // One restoring step: subtract the shifted divisor if it fits.
    always_comb begin
        take   = rem >= den_sh;
        q_next = {q[OFS_W-3:0], take};
    end

    // Start, iterate, and publish the signed quotient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            neg    <= 1'b0;
            rem    <= '0;
            den_sh <= '0;
            q      <= '0;
            step   <= '0;
            quot   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                neg <= diff[ACC_W-1];
                if (num >= lim) begin
                    quot <= diff[ACC_W-1] ? -QMAX : QMAX;
                    done <= 1'b1;
                    busy <= 1'b0;
                end else begin
                    busy   <= 1'b1;
                    rem    <= num;
                    den_sh <= DW'(nom) << (OFS_W - 2);
                    q      <= '0;
                    step   <= SW'(OFS_W - 2);
                end
            end else if (busy) begin
                if (take) rem <= rem - den_sh;
                den_sh <= den_sh >> 1;
                q      <= q_next;
                if (step == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    quot <= neg ? -$signed({1'b0, q_next}) : $signed({1'b0, q_next});
                end else begin
                    step <= step - 1'b1;
                end
            end
        end
    end

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R2

    AST_QUOT_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> quot != {1'b1, {(OFS_W-1){1'b0}}}); // R9

endmodule

// File: rtl/ref_freq_classifier.sv
// Top of the reference frequency classifier: gate counter, candidate
// matcher and serial offset divider in a chain. Each gate publishes
// index, valid flag and ppm offset together. Assumes GATE_CYCLES is
// well above OFS_W + 4 so the divider finishes inside one gate.
module ref_freq_classifier #(
    parameter int     GATE_CYCLES = 250000,
    parameter longint FREE_HZ     = 250_000_000,
    parameter int     TOL_PPM     = 100,
    parameter int     FRAC        = 24,
    parameter int     OFS_W       = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_edge,
    input  logic                    manual_mode,
    input  logic [14:0]             n_mult,
    output logic [3:0]              freq_idx,
    output logic                    match_valid,
    output logic signed [OFS_W-1:0] offset_ppm
);

    localparam int CNT_W = $clog2(GATE_CYCLES + 1);
    localparam int ACC_W = CNT_W + FRAC + 3;

    logic [CNT_W-1:0]        meas_cnt;
    logic                    meas_vld;
    logic                    cls_vld;
    logic                    cls_hit;
    logic [3:0]              cls_idx;
    logic [ACC_W-1:0]        cls_nom;
    logic signed [ACC_W-1:0] cls_diff;
    logic                    div_done;
    logic signed [OFS_W-1:0] div_quot;
    logic                    hit_q;
    logic [3:0]              idx_q;

    rfc_gate #(
        .GATE_CYCLES(GATE_CYCLES),
        .CNT_W      (CNT_W)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_stb(ref_edge),
        .meas_cnt(meas_cnt),
        .meas_vld(meas_vld)
    );

    rfc_match #(
        .GATE_CYCLES(GATE_CYCLES),
        .FREE_HZ    (FREE_HZ),
        .TOL_PPM    (TOL_PPM),
        .FRAC       (FRAC),
        .CNT_W      (CNT_W),
        .ACC_W      (ACC_W)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_vld   (meas_vld),
        .meas_cnt   (meas_cnt),
        .manual_mode(manual_mode),
        .n_mult     (n_mult),
        .cls_vld    (cls_vld),
        .cls_hit    (cls_hit),
        .cls_idx    (cls_idx),
        .cls_nom    (cls_nom),
        .cls_diff   (cls_diff)
    );

    rfc_ppm_div #(
        .ACC_W(ACC_W),
        .OFS_W(OFS_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(cls_vld),
        .diff (cls_diff),
        .nom  (cls_nom),
        .done (div_done),
        .quot (div_quot)
    );

    // Hold the classification while the divider works on its offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end else if (cls_vld) begin
            hit_q <= cls_hit;
            idx_q <= cls_idx;
        end
    end

    // Publish index, flag and offset together when the divide ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_idx    <= '0;
            match_valid <= 1'b0;
            offset_ppm  <= '0;
        end else if (div_done) begin
            freq_idx    <= hit_q ? idx_q : '0;
            match_valid <= hit_q;
            offset_ppm  <= hit_q ? div_quot : '0;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!match_valid && freq_idx == '0 && offset_ppm == '0)); // R1

    AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !div_done |=> ($stable(freq_idx) && $stable(match_valid) && $stable(offset_ppm))); // R2

    AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        !match_valid |-> (freq_idx == '0 && offset_ppm == '0)); // R6

    AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> (freq_idx <= 4'd12 || freq_idx == 4'hF)); // R3

    AST_MANUAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_done && hit_q && idx_q == 4'hF) |=> match_valid); // R7

endmodule

// File: tb/tb_ref_freq_classifier.sv
module tb_ref_freq_classifier;

    localparam int     CLK_PERIOD = 10;
    localparam int     GATE       = 2500;
    localparam longint FREE       = 250_000_000;
    localparam int     OFS_W      = 24;
    localparam int     SETTLE     = 2 * GATE + 100;
    localparam int     NVEC       = 16;

    typedef struct packed {
        logic        mode;
        logic [14:0] n;
        int          m;
        logic [3:0]  idx;
        logic        vld;
        int          ppm;
    } vec_t;

    // mode, N, strobes per gate, expected index, valid, ppm
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 15'd0,    1250, 4'd12, 1'b1, 0},
        '{1'b0, 15'd0,    500,  4'd10, 1'b1, 0},
        '{1'b0, 15'd0,    251,  4'd8,  1'b1, 4000},
        '{1'b0, 15'd0,    252,  4'd0,  1'b0, 0},
        '{1'b0, 15'd0,    194,  4'd7,  1'b1, -2057},
        '{1'b0, 15'd0,    777,  4'd11, 1'b1, -771},
        '{1'b0, 15'd0,    15,   4'd2,  1'b1, -28497},
        '{1'b0, 15'd0,    65,   4'd4,  1'b1, 3086},
        '{1'b0, 15'd0,    0,    4'd0,  1'b1, -1000000},
        '{1'b0, 15'd0,    1,    4'd0,  1'b1, 8388607},
        '{1'b1, 15'd3125, 250,  4'd15, 1'b1, 0},
        '{1'b1, 15'd3125, 260,  4'd0,  1'b0, 0},
        '{1'b1, 15'd0,    0,    4'd0,  1'b0, 0},
        '{1'b1, 15'd100,  9,    4'd15, 1'b1, 125000},
        '{1'b0, 15'd0,    389,  4'd9,  1'b1, 514},
        '{1'b0, 15'd0,    20,   4'd3,  1'b1, -23437}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    ref_edge = 1'b0;
    logic                    manual_mode = 1'b0;
    logic [14:0]             n_mult = '0;
    logic [3:0]              freq_idx;
    logic                    match_valid;
    logic signed [OFS_W-1:0] offset_ppm;

    int  per_gate = 0;
    int  acc = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ref_freq_classifier #(
        .GATE_CYCLES(GATE),
        .FREE_HZ    (FREE),
        .TOL_PPM    (100),
        .FRAC       (24),
        .OFS_W      (OFS_W)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_edge   (ref_edge),
        .manual_mode(manual_mode),
        .n_mult     (n_mult),
        .freq_idx   (freq_idx),
        .match_valid(match_valid),
        .offset_ppm (offset_ppm)
    );

    // Evenly spread strobes: exactly per_gate of them in any GATE cycles.
    always @(negedge clk) begin
        if (acc + per_gate >= GATE) begin
            acc = acc + per_gate - GATE;
            ref_edge <= 1'b1;
        end else begin
            acc = acc + per_gate;
            ref_edge <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag, input logic [3:0] e_idx,
                                 input logic e_vld, input int e_ppm);
        int diff;
        diff = int'(offset_ppm) - e_ppm;
        check(freq_idx == e_idx, {tag, " index R3 R5 R7 R10"}, int'(freq_idx), int'(e_idx));
        check(match_valid == e_vld, {tag, " valid R4 R6"}, int'(match_valid), int'(e_vld));
        check(diff >= -1 && diff <= 1, {tag, " offset R8 R9"}, int'(offset_ppm), e_ppm);
    endtask

    initial begin
        // R1: reset state
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_outputs("reset R1", 4'd0, 1'b0, 0);
        rst_n = 1'b1;

        // Vector walk without resets between entries (R10)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            manual_mode = VECS[i].mode;
            n_mult      = VECS[i].n;
            per_gate    = VECS[i].m;
            repeat (SETTLE) @(negedge clk);
            check_outputs($sformatf("vec%0d", i), VECS[i].idx, VECS[i].vld, VECS[i].ppm);
        end

        // R2: outputs hold steady across a full gate with constant input
        begin
            logic [3:0] i0;
            logic       v0;
            int         p0;
            int         moved;
            manual_mode = 1'b0;
            per_gate    = 500;
            repeat (SETTLE) @(negedge clk);
            i0 = freq_idx; v0 = match_valid; p0 = int'(offset_ppm); moved = 0;
            for (int c = 0; c < GATE; c++) begin
                @(negedge clk);
                if (freq_idx != i0 || match_valid != v0 || int'(offset_ppm) != p0) moved++;
            end
            check(moved == 0, "hold R2", moved, 0);
        end

        // R1: reset in mid-run clears outputs at the next edge
        rst_n = 1'b0;
        @(negedge clk);
        check_outputs("midreset R1", 4'd0, 1'b0, 0);
        rst_n = 1'b1;

        // R10: detection resumes after release without other action
        repeat (SETTLE) @(negedge clk);
        check_outputs("resume R10", 4'd10, 1'b1, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R2: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule